// File: doc/BRIEF.md
# Sixteen-Step Up/Down Sequencer Core

This block is the stepping engine of a sixteen-step sequencer. It holds the current step number, a run flag and a direction flag. It advances the step on rising edges of an oscillator level that is gated by the run flag, and on single-cycle pulses from step-forward and step-back buttons. A two-bit mode chooses how the count behaves when it reaches a selectable end step. The count can bounce back toward zero, wrap to zero, run over all sixteen steps, or take a fresh random value on every step.

The block drives a one-hot line for the active step, which can light an indicator or select an analog level. It also drives a gate that follows the gated oscillator during steps whose enable bit is set, and the gated oscillator itself. Everything runs on one system clock. The active-low reset is applied asynchronously and released through a two-stage synchronizer. After the reset input goes high, the core leaves reset on the second rising clock edge.

Top module: `step_seq_core`

## Requirements
- R1: While reset is held, and after it, the count is 0, the run flag is cleared (stopped), the direction is up, `step_o` is 16'h0001, and `gate_o` and `run_clk_o` are 0.
- R2: Each `run_btn_i` pulse toggles the run flag. While stopped, `run_clk_o` stays 0 and oscillator edges cause no steps. While running, `run_clk_o` equals `osc_i`.
- R3: While running, each rising edge of `osc_i`, sampled at a clock edge, gives one automatic step that is visible after that same edge. With no step source and no clear, the count holds.
- R4: A `up_btn_i` pulse adds 1 and a `dn_btn_i` pulse subtracts 1, modulo 16, so a step back from 0 gives 15. Both pulses in the same cycle cancel. Any manual pulse overrides an automatic step in the same cycle.
- R5: `clr_btn_i` sets the count to 0 on the next edge and wins over every other source.
- R6: Whenever the count is 0, the direction becomes up. The next automatic step from 0 goes to 1, in every mode except random.
- R7: Mode 0 (bounce): the end step is E = 4 + `end_sel_i`, and selections above 11 give E = 15. At E the direction turns down, so automatic steps sweep 0..E..0 repeatedly.
- R8: Mode 1 (wrap at end): any up step taken from E, automatic or manual, gives 0. The sequence is 0..E.
- R9: Mode 2 (full): automatic steps go through 0..15 and wrap, with no early turn or wrap.
- R10: Mode 3 (random): each automatic step loads `rand_i` into the count. Manual step pulses are ignored.
- R11: `step_o` has exactly one bit set, at the position equal to the count.
- R12: `gate_o` is `run_clk_o` ANDed with `gate_en_i[count]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_i | input | 1 | Step oscillator level |
| run_btn_i | input | 1 | Start/stop pulse, one cycle |
| up_btn_i | input | 1 | Manual step-forward pulse |
| dn_btn_i | input | 1 | Manual step-back pulse |
| clr_btn_i | input | 1 | Clear-count pulse |
| mode_i | input | 2 | 0 bounce, 1 wrap at end, 2 full, 3 random |
| end_sel_i | input | 4 | End step selection, E = 4 + value (clamped to 15) |
| rand_i | input | 4 | Random value loaded in mode 3 |
| gate_en_i | input | 16 | Per-step gate enables |
| count_o | output | 4 | Current step number |
| step_o | output | 16 | One-hot active step |
| gate_o | output | 1 | Gated oscillator for enabled steps |
| run_clk_o | output | 1 | Oscillator gated by the run flag |

## Verification
The bench targets the turn-around points:
- It runs past the end step and back through zero in bounce mode. A design that dropped the zero-forces-up rule would stick at zero or wrap to 15.
- It checks wrap-at-end on both manual and automatic steps.
- It selects end steps above 11, where a missing clamp would wrap the end value to a small number and shorten the sweep.
- It hits same-cycle collisions: clear with step, both manual buttons together, and a manual pulse with an oscillator edge. A wrong priority order gives an off-by-one count.
- In random mode it confirms that manual pulses leave the count alone.
- It confirms that stopping the sequencer holds both the count and the gated clock low.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    MODE_BOUNCE = 2'd0,
    MODE_WRAP   = 2'd1,
    MODE_FULL   = 2'd2,
    MODE_RANDOM = 2'd3
  } seq_mode_e;

endpackage

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_toggle_i,
  input  logic osc_i,
  output logic run_o,
  output logic run_clk_o,
  output logic auto_step_o
);

  logic run_q, run_d;
  logic osc_prev_q;
  logic run_clk;

  // next state
  always_comb begin
    run_d = run_q;
    if (run_toggle_i) run_d = ~run_q;
  end

  assign run_clk = osc_i & run_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      osc_prev_q <= 1'b0;
    end else begin
      if (run_toggle_i) run_q <= run_d;
      osc_prev_q <= run_clk;
    end
  end

  assign run_o       = run_q;
  assign run_clk_o   = run_clk;
  assign auto_step_o = run_clk & ~osc_prev_q;

  // R2: toggle pulse flips the run flag
  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_toggle_i |=> (run_o != $past(run_o)));

  // R2: stopped means no clock and no step
  p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (!auto_step_o && !run_clk_o));

endmodule

// File: rtl/seq_dir_ctrl.sv
module seq_dir_ctrl
  import seq_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] count_i,
  input  logic [STEP_W-1:0] end_step_i,
  input  seq_mode_e         mode_i,
  output logic              dir_up_o
);

  logic dir_q, dir_eff;

  // next state: zero forces up, end step in bounce mode forces down
  always_comb begin
    dir_eff = dir_q;
    if (count_i == '0)
      dir_eff = 1'b1;
    else if (mode_i == MODE_BOUNCE && count_i == end_step_i)
      dir_eff = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b1;
    else        dir_q <= dir_eff;
  end

  assign dir_up_o = dir_eff;

  // R6: registered direction is up one cycle after sitting at zero
  p_dir_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) |=> dir_q);

endmodule

// File: rtl/seq_step_counter.sv
module seq_step_counter
  import seq_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  seq_mode_e         mode_i,
  input  logic [STEP_W-1:0] end_step_i,
  input  logic              dir_up_i,
  input  logic              auto_i,
  input  logic              man_up_i,
  input  logic              man_dn_i,
  input  logic [STEP_W-1:0] load_val_i,
  output logic [STEP_W-1:0] count_o
);

  logic [STEP_W-1:0] count_q, count_d;
  logic [STEP_W-1:0] up_val, dn_val;
  logic              manual_any;

  always_comb begin
    up_val = count_q + 1'b1;
    if (mode_i == MODE_WRAP && count_q == end_step_i) up_val = '0;
    dn_val     = count_q - 1'b1;
    manual_any = man_up_i | man_dn_i;

    count_d = count_q;
    if (clr_i)
      count_d = '0;
    else if (mode_i == MODE_RANDOM) begin
      if (auto_i) count_d = load_val_i;
    end else if (manual_any) begin
      if (man_up_i && !man_dn_i)      count_d = up_val;
      else if (man_dn_i && !man_up_i) count_d = dn_val;
    end else if (auto_i)
      count_d = dir_up_i ? up_val : dn_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

  // R5: clear wins
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));

  // R3: no source, no change
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !auto_i && !man_up_i && !man_dn_i) |=> $stable(count_o));

  // R10: random mode loads the value on an automatic step
  p_rand_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RANDOM && auto_i && !clr_i) |=> (count_o == $past(load_val_i)));

  // R10: random mode ignores manual steps
  p_rand_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RANDOM && !auto_i && !clr_i) |=> $stable(count_o));

  // R8: up step from the end step returns to zero in wrap mode
  p_wrap_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_WRAP && !clr_i && man_up_i && !man_dn_i && count_o == end_step_i)
      |=> (count_o == '0));

endmodule

// File: rtl/seq_step_decode.sv
module seq_step_decode #(
  parameter int STEP_W = 4,
  parameter int NSTEPS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] count_i,
  input  logic              run_clk_i,
  input  logic [NSTEPS-1:0] gate_en_i,
  output logic [NSTEPS-1:0] step_o,
  output logic              gate_o
);

  logic [NSTEPS-1:0] gate_line;

  for (genvar g = 0; g < NSTEPS; g++) begin : g_step
    assign step_o[g]    = (count_i == STEP_W'(g));
    assign gate_line[g] = step_o[g] & gate_en_i[g];
  end

  assign gate_o = run_clk_i & (|gate_line);

  // R11: exactly one step line is active
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_o) == 1);

  // R12: gate only while the gated clock is high
  p_gate_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> run_clk_i);

endmodule

// File: rtl/step_seq_core.sv
module step_seq_core
  import seq_pkg::*;
#(
  parameter int STEP_W    = 4,
  parameter int END_SEL_W = 4,
  parameter int END_MIN   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    osc_i,
  input  logic                    run_btn_i,
  input  logic                    up_btn_i,
  input  logic                    dn_btn_i,
  input  logic                    clr_btn_i,
  input  logic [1:0]              mode_i,
  input  logic [END_SEL_W-1:0]    end_sel_i,
  input  logic [STEP_W-1:0]       rand_i,
  input  logic [(1<<STEP_W)-1:0]  gate_en_i,
  output logic [STEP_W-1:0]       count_o,
  output logic [(1<<STEP_W)-1:0]  step_o,
  output logic                    gate_o,
  output logic                    run_clk_o
);

  localparam int NSTEPS = 1 << STEP_W;
  localparam int SUM_W  = ((STEP_W > END_SEL_W) ? STEP_W : END_SEL_W) + 1;

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  seq_mode_e         mode;
  logic [SUM_W-1:0]  end_sum;
  logic [STEP_W-1:0] end_step;
  logic              run_flag, run_clk, auto_step, dir_up;
  logic [STEP_W-1:0] count;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign mode = seq_mode_e'(mode_i);

  // end step selection with clamp at the last step
  always_comb begin
    end_sum = SUM_W'(end_sel_i) + SUM_W'(END_MIN);
    if (end_sum > SUM_W'(NSTEPS - 1)) end_step = STEP_W'(NSTEPS - 1);
    else                              end_step = end_sum[STEP_W-1:0];
  end

  seq_run_ctrl u_run (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .run_toggle_i (run_btn_i),
    .osc_i        (osc_i),
    .run_o        (run_flag),
    .run_clk_o    (run_clk),
    .auto_step_o  (auto_step)
  );

  seq_dir_ctrl #(.STEP_W(STEP_W)) u_dir (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .count_i    (count),
    .end_step_i (end_step),
    .mode_i     (mode),
    .dir_up_o   (dir_up)
  );

  seq_step_counter #(.STEP_W(STEP_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr_i      (clr_btn_i),
    .mode_i     (mode),
    .end_step_i (end_step),
    .dir_up_i   (dir_up),
    .auto_i     (auto_step),
    .man_up_i   (up_btn_i),
    .man_dn_i   (dn_btn_i),
    .load_val_i (rand_i),
    .count_o    (count)
  );

  seq_step_decode #(.STEP_W(STEP_W), .NSTEPS(NSTEPS)) u_dec (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .count_i   (count),
    .run_clk_i (run_clk),
    .gate_en_i (gate_en_i),
    .step_o    (step_o),
    .gate_o    (gate_o)
  );

  assign count_o   = count;
  assign run_clk_o = run_clk;

  // R6: automatic step out of zero always climbs
  p_zero_up_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (count == '0 && mode != MODE_RANDOM && auto_step && !clr_btn_i && !up_btn_i && !dn_btn_i)
      |=> (count_o == STEP_W'(1)));

  // R7: automatic step at the end step in bounce mode descends
  p_bounce_down_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode == MODE_BOUNCE && count == end_step && auto_step && !clr_btn_i && !up_btn_i && !dn_btn_i)
      |=> (count_o == STEP_W'($past(count_o) - 1'b1)));

  // R1: core reset leaves the sequencer stopped
  p_reset_stopped_r1: assert property (@(posedge clk)
    !rst_core_n |-> (!run_clk_o && count_o == '0));

endmodule

// File: tb/step_seq_core_bench.sv
module step_seq_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        osc, run_b, up_b, dn_b, clr_b;
  logic [1:0]  mode;
  logic [3:0]  end_sel, rnd;
  logic [15:0] gate_en;
  logic [3:0]  count;
  logic [15:0] step;
  logic        gate, run_clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  step_seq_core u_step_seq_core (
    .clk(clk), .rst_n(rst_n), .osc_i(osc), .run_btn_i(run_b),
    .up_btn_i(up_b), .dn_btn_i(dn_b), .clr_btn_i(clr_b),
    .mode_i(mode), .end_sel_i(end_sel), .rand_i(rnd), .gate_en_i(gate_en),
    .count_o(count), .step_o(step), .gate_o(gate), .run_clk_o(run_clk)
  );

  // {mode, end_sel, ticks, expected count} from a cleared start
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 4'd0,  8'd6,  4'd2},
    {2'd0, 4'd0,  8'd10, 4'd2},
    {2'd0, 4'd11, 8'd17, 4'd13},
    {2'd0, 4'd13, 8'd16, 4'd14},
    {2'd1, 4'd2,  8'd7,  4'd0},
    {2'd1, 4'd2,  8'd9,  4'd2},
    {2'd2, 4'd0,  8'd17, 4'd1},
    {2'd2, 4'd15, 8'd5,  4'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input logic u, input logic d, input logic c, input logic r);
    @(negedge clk);
    up_b = u; dn_b = d; clr_b = c; run_b = r;
    @(negedge clk);
    up_b = 1'b0; dn_b = 1'b0; clr_b = 1'b0; run_b = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); osc = 1'b1;
    @(negedge clk); osc = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; osc = 1'b0; run_b = 1'b0; up_b = 1'b0; dn_b = 1'b0; clr_b = 1'b0;
    mode = 2'd2; end_sel = 4'd0; rnd = 4'd0; gate_en = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 count", count, 0);
    check("R1 step", step, 16'h0001);
    check("R1 gate", gate, 0);
    check("R1 run_clk", run_clk, 0);

    // R2 stopped: no steps, clock held low
    tick();
    check("R2 no step while stopped", count, 0);
    @(negedge clk); osc = 1'b1;
    @(negedge clk);
    check("R2 run_clk low while stopped", run_clk, 0);
    osc = 1'b0;

    // R2 / R3 start and auto step
    press(0, 0, 0, 1);
    @(negedge clk); osc = 1'b1;
    @(negedge clk);
    check("R2 run_clk follows osc", run_clk, 1);
    check("R3 auto step", count, 1);
    osc = 1'b0;
    @(negedge clk);

    // R4 manual steps
    press(1, 0, 0, 0); check("R4 manual up", count, 2);
    press(0, 1, 0, 0); check("R4 manual down", count, 1);
    press(0, 1, 0, 0);
    press(0, 1, 0, 0); check("R4 down wraps from 0", count, 15);
    press(1, 1, 0, 0); check("R4 both cancel", count, 15);
    @(negedge clk); dn_b = 1'b1; osc = 1'b1;
    @(negedge clk); dn_b = 1'b0; osc = 1'b0;
    check("R4 manual overrides auto", count, 14);

    // R5 clear priority
    press(1, 0, 1, 0); check("R5 clear beats step", count, 0);

    // R7 / R5 / R6 bounce with E=4
    mode = 2'd0; end_sel = 4'd0;
    press(0, 0, 1, 0);
    repeat (5) tick();
    check("R7 descending after end", count, 3);
    press(0, 0, 1, 0); check("R5 clear", count, 0);
    tick(); check("R6 climbs from zero", count, 1);

    // R8 manual up from end step
    mode = 2'd1; end_sel = 4'd0;
    press(0, 0, 1, 0);
    repeat (4) press(1, 0, 0, 0);
    check("R8 at end step", count, 4);
    press(1, 0, 0, 0); check("R8 manual up wraps at end", count, 0);

    // R10 random mode
    mode = 2'd3; rnd = 4'd9;
    tick(); check("R10 load on tick", count, 9);
    rnd = 4'd3;
    press(1, 0, 0, 0); check("R10 manual ignored", count, 9);
    tick(); check("R10 second load", count, 3);
    press(0, 0, 1, 0); check("R5 clear in random", count, 0);

    // table of mode sweeps
    for (int i = 0; i < 8; i++) begin
      logic [17:0] row;
      string tag;
      row = VEC[i];
      mode = row[17:16]; end_sel = row[15:12];
      tag = (row[17:16] == 2'd0) ? "R7" : (row[17:16] == 2'd1) ? "R8" : "R9";
      press(0, 0, 1, 0);
      for (int t = 0; t < int'(row[11:4]); t++) tick();
      check($sformatf("%s row %0d count", tag, i), count, row[3:0]);
      check($sformatf("R11 row %0d step", i), step, 32'd1 << row[3:0]);
    end

    // R12 gate
    mode = 2'd2; gate_en = 16'h0008;
    press(0, 0, 1, 0);
    tick(); tick();
    check("R12 gate low with osc low", gate, 0);
    @(negedge clk); osc = 1'b1;
    @(negedge clk);
    check("R12 gate on enabled step", gate, 1);
    check("R11 step line", step, 16'h0008);
    gate_en = 16'h0000; #1;
    check("R12 gate off when disabled", gate, 0);
    gate_en = 16'h0008;
    @(negedge clk); osc = 1'b0; #1;
    check("R12 gate follows clock low", gate, 0);

    // R2 stop again
    press(0, 0, 0, 1);
    @(negedge clk); osc = 1'b1;
    @(negedge clk);
    check("R2 stopped run_clk", run_clk, 0);
    check("R2 stopped count holds", count, 3);
    osc = 1'b0;

    // R1 asynchronous reset
    @(negedge clk); rst_n = 1'b0; #1;
    check("R1 reset count", count, 0);
    check("R1 reset step", step, 16'h0001);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule